// File: doc/BRIEF.md
# Windowed Watchdog Timer with Lock-After-First-Write Configuration

This block watches for software that has stopped running properly. A counter advances either on every system clock cycle or on each pulse of a slow 1 kHz tick-enable input. When the counter reaches its limit, the block issues a one-cycle reset request. Software keeps the counter from reaching the limit by writing a two-byte key pair to a service address. Each completed pair sends the counter back to zero.

A configuration register chooses the limit, the count source and an optional window mode. The limit is a power of two and depends on both the source and a 2-bit period select. The register accepts only its first write after reset and ignores all later writes, so a program that has gone astray cannot weaken the watchdog. In window mode the counter must be in the last quarter of its period when software services it. A write to the service address earlier than that is treated as a fault and raises the reset request at once.

All register accesses use a single write strobe with an address and a data word. The block has no read path.

Top module: `wdog_window`

## Requirements
- R1: After reset, `rst_req` is low and the counter is zero. The configuration is period select 2'b11, count source 1 kHz tick and window off, so the watchdog runs at once with the longest tick period.
- R2: Period select 2'b00 stops the counter. No reset request is ever raised, whatever is written to the service address.
- R3: With count source 0, the counter advances only in cycles where `tick_1k` is high. Period selects 01, 10 and 11 give limits of 2^TICK_EXP_SHORT, 2^TICK_EXP_MID and 2^TICK_EXP_LONG ticks.
- R4: With count source 1, the counter advances every clock cycle. Period selects 01, 10 and 11 give limits of 2^CLK_EXP_SHORT, 2^CLK_EXP_MID and 2^CLK_EXP_LONG cycles.
- R5: The increment that makes the limit-th count, or any increment while the counter is already at or above limit-1, clears the counter. `rst_req` is then high for exactly the next clock cycle.
- R6: A write to address CFG_ADDR (default 0) loads the configuration from the data word: bits [1:0] are the period select, bit 2 is the count source and bit 3 is the window enable. Only the first such write after reset is taken. Later writes change nothing.
- R7: At address SVC_ADDR (default 1), a write of 0x55 followed by a write of 0xAA clears the counter. Other cycles may come between the two writes, but no other service write may. If the 0xAA completes in the same cycle as an expiring increment, the service wins and no request is raised.
- R8: After 0x55, a write of any value other than 0xAA or 0x55 drops the pending key without servicing. A repeated 0x55 keeps the key pending, so 0x55, 0x55, 0xAA services the watchdog.
- R9: Window mode is active when the window enable and count source 1 are set and the period select is not 00. In that mode, any service write while the counter is below 3/4 of the limit raises `rst_req` in the next cycle and clears both the counter and the pending key.
- R10: In window mode, a key pair written while the counter is at or above 3/4 of the limit services the watchdog normally.
- R11: With count source 0, the window enable has no effect, and early service writes work as in normal mode.
- R12: Writes to any address other than CFG_ADDR and SVC_ADDR change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the fast count source |
| rst_n | input | 1 | Active-low synchronous reset; the only way to unlock the configuration |
| tick_1k | input | 1 | One-cycle enable pulse from the slow 1 kHz time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The main function is tested with the counter left unserviced under both count sources and several period selects. These runs show that the correct limit is picked for each source and that the request is exactly one cycle long. Service patterns are also tried:
- clean key pairs,
- a pair broken by a stray byte,
- a doubled 0x55,
- a pair that lands on the expiring cycle.

Together these separate a correct key tracker from one that is too lenient or too strict. In window mode, service writes are placed just before and just after the 3/4 point of the period. Window mode is also tried with the tick source, where early writes must not count as faults. A second configuration write and a write to an unused address are each followed by a run that would show any change in the period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int CFG_TSEL_LSB = 0;
   localparam int CFG_SRC_BIT  = 2;
   localparam int CFG_WIN_BIT  = 3;
   localparam int CFG_USED_W   = 4;

   localparam logic [7:0] KEY_ARM  = 8'h55;
   localparam logic [7:0] KEY_FIRE = 8'hAA;

   typedef enum logic [1:0] {
      TO_OFF   = 2'b00,
      TO_SHORT = 2'b01,
      TO_MID   = 2'b10,
      TO_LONG  = 2'b11
   } tsel_e;

   typedef struct packed {
      logic  win_en;
      logic  src_clk;
      tsel_e tsel;
   } wd_cfg_t;

   localparam wd_cfg_t CFG_RESET = '{win_en: 1'b0, src_clk: 1'b0, tsel: TO_LONG};

   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_ARMED = 1'b1
   } seq_e;

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
   import wdog_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] wdata,
   output wd_cfg_t           cfg,
   output logic              locked
);

   initial begin
      if (DATA_W < CFG_USED_W) $fatal(1, "wdog_cfg_reg: DATA_W too small for config fields");
   end

   // First write after reset loads every field and closes the lock.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg    <= CFG_RESET;
         locked <= 1'b0;
      end else if (cfg_wr && !locked) begin
         cfg.tsel    <= tsel_e'(wdata[CFG_TSEL_LSB +: 2]);
         cfg.src_clk <= wdata[CFG_SRC_BIT];
         cfg.win_en  <= wdata[CFG_WIN_BIT];
         locked      <= 1'b1;
      end
   end

endmodule

// File: rtl/wdog_limits.sv
module wdog_limits
   import wdog_pkg::*;
#(
   parameter int TICK_EXP_SHORT = 5,
   parameter int TICK_EXP_MID   = 8,
   parameter int TICK_EXP_LONG  = 10,
   parameter int CLK_EXP_SHORT  = 13,
   parameter int CLK_EXP_MID    = 16,
   parameter int CLK_EXP_LONG   = 18,
   parameter int LIM_W          = 19
) (
   input  wd_cfg_t          cfg,
   output logic [LIM_W-1:0] lim,
   output logic [LIM_W-1:0] open_at,
   output logic             enabled,
   output logic             win_act
);

   localparam int NSEL = 3;
   localparam int TEXP [NSEL] = '{TICK_EXP_SHORT, TICK_EXP_MID, TICK_EXP_LONG};
   localparam int CEXP [NSEL] = '{CLK_EXP_SHORT, CLK_EXP_MID, CLK_EXP_LONG};

   initial begin
      for (int i = 0; i < NSEL; i++) begin
         if (TEXP[i] < 2 || CEXP[i] < 2)
            $fatal(1, "wdog_limits: exponents must be at least 2 for an exact 3/4 point");
         if (TEXP[i] >= LIM_W || CEXP[i] >= LIM_W)
            $fatal(1, "wdog_limits: exponent does not fit LIM_W");
      end
   end

   logic [LIM_W-1:0] tick_lim [NSEL];
   logic [LIM_W-1:0] clk_lim  [NSEL];

   for (genvar g = 0; g < NSEL; g++) begin : g_lim
      assign tick_lim[g] = LIM_W'(1) << TEXP[g];
      assign clk_lim[g]  = LIM_W'(1) << CEXP[g];
   end

   logic [LIM_W-1:0] pick [NSEL];

   for (genvar g = 0; g < NSEL; g++) begin : g_pick
      assign pick[g] = cfg.src_clk ? clk_lim[g] : tick_lim[g];
   end

   always_comb begin
      case (cfg.tsel)
         TO_SHORT: lim = pick[0];
         TO_MID:   lim = pick[1];
         TO_LONG:  lim = pick[2];
         default:  lim = '0;
      endcase
      enabled = (cfg.tsel != TO_OFF);
      open_at = lim - (lim >> 2);
      win_act = enabled && cfg.src_clk && cfg.win_en;
   end

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
   import wdog_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              svc_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              early,
   output logic              svc_done,
   output logic              fault
);

   initial begin
      if (DATA_W < 8) $fatal(1, "wdog_seq: keys need at least 8 data bits");
   end

   seq_e st;
   logic is_arm;
   logic is_fire;

   always_comb begin
      is_arm   = (wdata == DATA_W'(KEY_ARM));
      is_fire  = (wdata == DATA_W'(KEY_FIRE));
      fault    = svc_wr && early;
      svc_done = svc_wr && !early && is_fire && (st == SEQ_ARMED);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= SEQ_IDLE;
      end else if (svc_wr) begin
         if (fault)       st <= SEQ_IDLE;
         else if (is_arm) st <= SEQ_ARMED;
         else             st <= SEQ_IDLE;
      end
   end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int LIM_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   input  logic [LIM_W-1:0] lim,
   output logic [LIM_W-1:0] cnt,
   output logic             expire
);

   // Compare with >= so a count left above a newly shortened limit still expires.
   always_comb begin
      expire = inc && !clr && (cnt >= (lim - LIM_W'(1)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (expire)  cnt <= '0;
      else if (inc)     cnt <= cnt + LIM_W'(1);
   end

endmodule

// File: rtl/wdog_window.sv
module wdog_window
   import wdog_pkg::*;
#(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 8,
   parameter int CFG_ADDR       = 0,
   parameter int SVC_ADDR       = 1,
   parameter int TICK_EXP_SHORT = 5,
   parameter int TICK_EXP_MID   = 8,
   parameter int TICK_EXP_LONG  = 10,
   parameter int CLK_EXP_SHORT  = 13,
   parameter int CLK_EXP_MID    = 16,
   parameter int CLK_EXP_LONG   = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1k,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rst_req
);

   localparam int MAX_T   = (TICK_EXP_LONG > TICK_EXP_MID) ?
                            ((TICK_EXP_LONG > TICK_EXP_SHORT) ? TICK_EXP_LONG : TICK_EXP_SHORT) :
                            ((TICK_EXP_MID > TICK_EXP_SHORT) ? TICK_EXP_MID : TICK_EXP_SHORT);
   localparam int MAX_C   = (CLK_EXP_LONG > CLK_EXP_MID) ?
                            ((CLK_EXP_LONG > CLK_EXP_SHORT) ? CLK_EXP_LONG : CLK_EXP_SHORT) :
                            ((CLK_EXP_MID > CLK_EXP_SHORT) ? CLK_EXP_MID : CLK_EXP_SHORT);
   localparam int MAX_EXP = (MAX_T > MAX_C) ? MAX_T : MAX_C;
   localparam int LIM_W   = MAX_EXP + 1;

   initial begin
      if (CFG_ADDR == SVC_ADDR) $fatal(1, "wdog_window: config and service addresses collide");
      if (CFG_ADDR >= (1 << ADDR_W) || SVC_ADDR >= (1 << ADDR_W))
         $fatal(1, "wdog_window: address out of range for ADDR_W");
   end

   wd_cfg_t          cfg;
   logic             cfg_locked;
   logic             cfg_wr;
   logic             svc_wr;
   logic [LIM_W-1:0] lim;
   logic [LIM_W-1:0] open_at;
   logic             enabled;
   logic             win_act;
   logic [LIM_W-1:0] cnt;
   logic             expire;
   logic             early;
   logic             inc;
   logic             svc_done;
   logic             fault;

   always_comb begin
      cfg_wr = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
      svc_wr = wr_en && (wr_addr == ADDR_W'(SVC_ADDR));
      inc    = enabled && (cfg.src_clk || tick_1k);
      early  = win_act && (cnt < open_at);
   end

   wdog_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_wr (cfg_wr),
      .wdata  (wr_data),
      .cfg    (cfg),
      .locked (cfg_locked)
   );

   wdog_limits #(
      .TICK_EXP_SHORT (TICK_EXP_SHORT),
      .TICK_EXP_MID   (TICK_EXP_MID),
      .TICK_EXP_LONG  (TICK_EXP_LONG),
      .CLK_EXP_SHORT  (CLK_EXP_SHORT),
      .CLK_EXP_MID    (CLK_EXP_MID),
      .CLK_EXP_LONG   (CLK_EXP_LONG),
      .LIM_W          (LIM_W)
   ) u_lim (
      .cfg     (cfg),
      .lim     (lim),
      .open_at (open_at),
      .enabled (enabled),
      .win_act (win_act)
   );

   wdog_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .svc_wr   (svc_wr),
      .wdata    (wr_data),
      .early    (early),
      .svc_done (svc_done),
      .fault    (fault)
   );

   wdog_counter #(.LIM_W(LIM_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc),
      .clr    (svc_done || fault),
      .lim    (lim),
      .cnt    (cnt),
      .expire (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= expire || fault;
   end

endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk #(
   parameter int LIM_W = 19
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       cfg_bits,
   input logic             locked,
   input logic [LIM_W-1:0] cnt,
   input logic             expire,
   input logic             svc_wr,
   input logic             svc_done,
   input logic             early,
   input logic             rst_req
);

   p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> (locked && $stable(cfg_bits)));

   p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits[1:0] == 2'b00) |=> !rst_req);

   p_expire_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (rst_req && cnt == '0));

   p_expire_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

   p_svc_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      svc_done |=> (cnt == '0));

   p_early_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_wr && early) |=> (rst_req && cnt == '0));

endmodule

bind wdog_window wdog_window_chk #(.LIM_W(LIM_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_bits (cfg),
   .locked   (cfg_locked),
   .cnt      (cnt),
   .expire   (expire),
   .svc_wr   (svc_wr),
   .svc_done (svc_done),
   .early    (early),
   .rst_req  (rst_req)
);

// File: tb/wdog_window_bench.sv
`timescale 1ns/1ps
module wdog_window_bench;

   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam int TE [3] = '{3, 4, 5};
   localparam int CE [3] = '{5, 6, 7};
   localparam int TICK_PER = 4;
   localparam logic [ADDR_W-1:0] A_CFG = 0;
   localparam logic [ADDR_W-1:0] A_SVC = 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_1k = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rst_req;

   always #2 clk = ~clk;

   wdog_window #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(0), .SVC_ADDR(1),
      .TICK_EXP_SHORT(TE[0]), .TICK_EXP_MID(TE[1]), .TICK_EXP_LONG(TE[2]),
      .CLK_EXP_SHORT(CE[0]), .CLK_EXP_MID(CE[1]), .CLK_EXP_LONG(CE[2])
   ) u_wdog_window (
      .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(rst_req)
   );

   int    errors = 0;
   int    checks = 0;
   int    pulses = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // Behavioural reference state
   int m_tsel, m_src, m_win, m_lock, m_cnt, m_arm, m_req;

   function automatic int limit_of(int tsel, int src);
      if (tsel == 0) return 0;
      return src ? (1 << CE[tsel-1]) : (1 << TE[tsel-1]);
   endfunction

   // Slow tick: one cycle high out of TICK_PER
   int tdiv = 0;
   always @(negedge clk) begin
      tdiv    = (tdiv + 1) % TICK_PER;
      tick_1k = (tdiv == 0);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tsel = 3; m_src = 0; m_win = 0; m_lock = 0;
         m_cnt = 0; m_arm = 0; m_req = 0;
      end else begin
         int lim, n_cnt, n_arm, n_req;
         bit en, step, winm, svc, flt;
         lim  = limit_of(m_tsel, m_src);
         en   = (m_tsel != 0);
         step = en && (m_src != 0 || tick_1k);
         winm = en && m_src != 0 && m_win != 0;
         svc = 0; flt = 0;
         n_arm = m_arm; n_cnt = m_cnt; n_req = 0;
         if (wr_en && wr_addr == A_SVC) begin
            if (winm && m_cnt < lim - lim / 4) begin
               flt = 1; n_arm = 0;
            end else if (wr_data == 8'h55) n_arm = 1;
            else if (wr_data == 8'hAA && m_arm != 0) begin
               svc = 1; n_arm = 0;
            end else n_arm = 0;
         end
         if (flt || svc) n_cnt = 0;
         else if (step) begin
            if (m_cnt >= lim - 1) begin n_cnt = 0; n_req = 1; end
            else n_cnt = m_cnt + 1;
         end
         if (flt) n_req = 1;
         if (wr_en && wr_addr == A_CFG && m_lock == 0) begin
            m_tsel = int'(wr_data[1:0]); m_src = int'(wr_data[2]);
            m_win = int'(wr_data[3]); m_lock = 1;
         end
         m_cnt = n_cnt; m_arm = n_arm; m_req = n_req;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare with the model on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(rst_req === m_req[0], cur_req, int'(rst_req), m_req);
         if (rst_req === 1'b1) pulses++;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      pulses = 0;
   endtask

   task automatic service();
      wr(A_SVC, 8'h55);
      wr(A_SVC, 8'hAA);
   endtask

   initial begin
      @(negedge clk);
      // R1: reset state and default longest tick period (32 ticks x 4 cycles)
      cur_req = "R1";
      do_reset();
      check(rst_req === 1'b0, "R1 reset rst_req", int'(rst_req), 0);
      idle(140);
      check(pulses == 1, "R1 default period pulse count", pulses, 1);

      // R4/R5: clock source, short period = 32 cycles
      cur_req = "R4";
      do_reset();
      wr(A_CFG, 8'h05);
      idle(110);
      check(pulses == 3, "R4 R5 clock source pulses", pulses, 3);

      // R2: disabled period select
      cur_req = "R2";
      do_reset();
      wr(A_CFG, 8'h04);
      wr(A_SVC, 8'h12);
      idle(300);
      check(pulses == 0, "R2 disabled pulses", pulses, 0);

      // R6: second config write ignored
      cur_req = "R6";
      do_reset();
      wr(A_CFG, 8'h05);
      wr(A_CFG, 8'h00);
      idle(110);
      check(pulses == 3, "R6 second write ignored", pulses, 3);

      // R3: tick source short period = 8 ticks
      cur_req = "R3";
      do_reset();
      wr(A_CFG, 8'h01);
      idle(110);
      check(pulses == 3, "R3 tick source pulses", pulses, 3);

      // R12: write to unused address ignored, config stays unlocked
      cur_req = "R12";
      do_reset();
      wr(4'd5, 8'h04);
      wr(A_CFG, 8'h05);
      idle(110);
      check(pulses == 3, "R12 stray address ignored", pulses, 3);

      // R7: regular servicing keeps the request away (period 64)
      cur_req = "R7";
      do_reset();
      wr(A_CFG, 8'h06);
      for (int i = 0; i < 7; i++) begin
         service();
         idle(38);
      end
      check(pulses == 0, "R7 serviced pulses", pulses, 0);

      // R7 corner: 0xAA lands on the expiring cycle
      while (m_cnt != 62) @(negedge clk);
      service();
      idle(10);
      check(pulses == 0, "R7 service beats expiry", pulses, 0);

      // R8: broken pair does not service
      cur_req = "R8";
      do_reset();
      wr(A_CFG, 8'h06);
      for (int i = 0; i < 5; i++) begin
         wr(A_SVC, 8'h55);
         wr(A_SVC, 8'h12);
         wr(A_SVC, 8'hAA);
         idle(37);
      end
      check(pulses >= 2, "R8 broken pair expired", pulses, 2);
      pulses = 0;
      for (int i = 0; i < 5; i++) begin
         wr(A_SVC, 8'h55);
         wr(A_SVC, 8'h55);
         wr(A_SVC, 8'hAA);
         idle(37);
      end
      check(pulses == 0, "R8 doubled arm services", pulses, 0);

      // R9: early write in window mode (limit 32, opens at 24)
      cur_req = "R9";
      do_reset();
      wr(A_CFG, 8'h0D);
      idle(5);
      wr(A_SVC, 8'h55);
      check(rst_req === 1'b1, "R9 early write request", int'(rst_req), 1);
      idle(2);
      check(pulses == 1, "R9 single fault pulse", pulses, 1);

      // R10: servicing inside the last quarter
      cur_req = "R10";
      do_reset();
      wr(A_CFG, 8'h0D);
      for (int i = 0; i < 6; i++) begin
         while (m_cnt != 25) @(negedge clk);
         service();
      end
      idle(5);
      check(pulses == 0, "R10 in-window service", pulses, 0);

      // R11: window enable ignored with tick source (limit 8 ticks)
      cur_req = "R11";
      do_reset();
      wr(A_CFG, 8'h09);
      for (int i = 0; i < 8; i++) begin
         service();
         idle(14);
      end
      check(pulses == 0, "R11 window ignored on tick", pulses, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule